// File: doc/BRIEF.md
# Round Key Store

This block keeps the eleven 128-bit round keys of an AES-128 key schedule and hands them to the AddRoundKey stage one 32-bit slice at a time. A key expansion unit loads the schedule one 32-bit word per cycle. The first key, which is the cipher key itself, goes into a small 128-bit holding register. The ten derived keys go into forty byte-wide, four-entry sub-memories, with no reset, standing in for ROM. The sub-memories for round `r` (1..10) are numbered `(r-1)*4 + b`, where byte lane `b` is bits `[8b+7:8b]` of a word. Each one stores its lane of slice `s` at address `s`.

The consumer asks for a slice with `rd_req`, `rd_round` and `rd_slice`. A full round key therefore streams out in four back-to-back requests. The result is registered and comes back one cycle later with a `key_valid` pulse. Until the whole schedule has been loaded, there is no stored copy to read. During that time a request is served straight from the word the generator drives in the same cycle. This is how the first data block gets its keys while expansion is still running. When the last word (round 10, slice 3) is accepted, `keys_ready` latches high and write-protects the store. A pulse on `ld_start` reopens the store for a new key.

Top module: `rks_store`

## Requirements
- R1: During and straight after reset, `key_valid`, `key_err` and `keys_ready` are 0 and `key_slice` is all zeros.
- R2: A load word (`ld_valid`=1, `ld_start`=0, `keys_ready`=0) with `ld_round` between 1 and 10 is stored. A later read of that round and slice returns that word.
- R3: `keys_ready` goes high in the cycle after the load of round 10, slice 3 is accepted. It stays 0 before that.
- R4: While `keys_ready`=1, load words are ignored. A read of the targeted round and slice, round 0 included, still returns the earlier word.
- R5: `ld_start`=1 clears `keys_ready` in the next cycle, and a load word presented in that same cycle is not stored. After that a complete new schedule can be loaded, and its words replace the old ones.
- R6: The result of a request is on `key_slice`, with `key_valid`=1, in the cycle after the request. Four requests in consecutive cycles give four consecutive valid slices. In a cycle with no request, `key_valid` and `key_err` are 0 in the next cycle.
- R7: A read of round 0 returns the slice of the cipher key that was loaded with `ld_round`=0.
- R8: A request with `rd_round` above 10 gives `key_err`=1, `key_valid`=0 and `key_slice`=0 in the next cycle.
- R9: While `keys_ready`=0, a request returns the `ld_word` driven in the same cycle, with `key_valid`=1, if `ld_valid`=1. If `ld_valid`=0 it gives `key_valid`=0 and `key_slice`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_start | input | 1 | Begin a new key load; clears `keys_ready` |
| ld_valid | input | 1 | Load word present |
| ld_round | input | 4 | Round of the load word (0..10) |
| ld_slice | input | 2 | Slice of the load word within its round |
| ld_word | input | 32 | Key word from the expansion unit |
| rd_req | input | 1 | Slice request |
| rd_round | input | 4 | Requested round |
| rd_slice | input | 2 | Requested slice |
| key_slice | output | 32 | Registered key slice |
| key_valid | output | 1 | `key_slice` holds a requested key |
| key_err | output | 1 | Request named a round above 10 |
| keys_ready | output | 1 | Whole schedule stored; writes locked |

## Verification
A fault in the write decode or the lane wiring corrupts the stored bytes in silence. It only shows when that round and slice is read back, one cycle after the request, as a wrong byte in one lane. For that reason every slice of every round is read and compared with its own distinct value. A `keys_ready` flag that is stuck or sets too early shows up at once on the port. It also shows indirectly: reads switch between bypass data and stored data, and locked writes get through or fail to. Those cases are checked right after the last load word and after a reload pulse.

// File: rtl/rks_pkg.sv
// Package: default geometry of the round key store.
// Assumes AES-128: ten derived round keys plus the cipher key,
// each four 32-bit slices made of four byte lanes.
package rks_pkg;
    localparam int unsigned RKS_ROUNDS = 10;
    localparam int unsigned RKS_SLICES = 4;
    localparam int unsigned RKS_LANES  = 4;
    localparam int unsigned RKS_BYTE_W = 8;
endpackage

// File: rtl/rks_byte_mem.sv
// Module: one byte-wide sub-memory with DEPTH entries.
// Write port is synchronous, read port is asynchronous. The contents have
// no reset, like a ROM image that is filled once by key expansion.
module rks_byte_mem #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] cells [DEPTH];

    // Store one byte when the entry is enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/rks_seed_hold.sv
// Module: holding register for the round-0 (cipher) key.
// Written one slice per cycle. Reads one slice combinationally.
// Resets to zero.
module rks_seed_hold #(
    parameter int unsigned SLICES = 4,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned SLC_W = (SLICES > 1) ? $clog2(SLICES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLC_W-1:0]  wslice,
    input  logic [WORD_W-1:0] wword,
    input  logic [SLC_W-1:0]  rslice,
    output logic [WORD_W-1:0] rword
);
    logic [WORD_W-1:0] seed_q [SLICES];

    // Clear on reset, otherwise capture the addressed slice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(SLICES); i++) seed_q[i] <= '0;
        end else if (we) begin
            seed_q[wslice] <= wword;
        end
    end

    assign rword = seed_q[rslice];
endmodule

// File: rtl/rks_bank.sv
// Module: array of NUM_ROUNDS*LANES byte sub-memories for rounds 1..NUM_ROUNDS.
// The memory for round r, lane b sits at index (r-1)*LANES+b and keeps
// its lane of slice s at address s. A round outside 1..NUM_ROUNDS reads zero
// and is never written.
module rks_bank #(
    parameter int unsigned NUM_ROUNDS = 10,
    parameter int unsigned SLICES     = 4,
    parameter int unsigned LANES      = 4,
    parameter int unsigned BYTE_W     = 8,
    localparam int unsigned WORD_W    = LANES * BYTE_W,
    localparam int unsigned RND_W     = $clog2(NUM_ROUNDS + 1),
    localparam int unsigned SLC_W     = (SLICES > 1) ? $clog2(SLICES) : 1,
    localparam int unsigned NMEM      = NUM_ROUNDS * LANES
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [RND_W-1:0]  wr_round,
    input  logic [SLC_W-1:0]  wr_slice,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [RND_W-1:0]  rd_round,
    input  logic [SLC_W-1:0]  rd_slice,
    output logic [WORD_W-1:0] rd_word
);
    logic [BYTE_W-1:0] lane_q [NMEM];

    for (genvar r = 1; r <= int'(NUM_ROUNDS); r++) begin : g_round
        logic round_we;
        assign round_we = wr_en && (wr_round == RND_W'(r));
        for (genvar b = 0; b < int'(LANES); b++) begin : g_lane
            rks_byte_mem #(.BYTE_W(BYTE_W), .DEPTH(SLICES)) u_mem (
                .clk   (clk),
                .we    (round_we),
                .waddr (wr_slice),
                .wdata (wr_word[b*BYTE_W +: BYTE_W]),
                .raddr (rd_slice),
                .rdata (lane_q[(r-1)*LANES + b])
            );
        end
    end

    // Pick the four lanes of the requested round.
    always_comb begin
        rd_word = '0;
        for (int r = 1; r <= int'(NUM_ROUNDS); r++) begin
            if (rd_round == RND_W'(r)) begin
                for (int b = 0; b < int'(LANES); b++) begin
                    rd_word[b*BYTE_W +: BYTE_W] = lane_q[(r-1)*LANES + b];
                end
            end
        end
    end
endmodule

// File: rtl/rks_store.sv
// Module: round key store top.
// Accepts the key schedule one word per cycle and locks it when the last
// word arrives. It serves one registered slice per request. Before the lock,
// requests bypass to the word being loaded. Assumes the loader drives rounds
// 0..NUM_ROUNDS with each slice once per load and pulses ld_start before a
// reload.
module rks_store #(
    parameter int unsigned NUM_ROUNDS = rks_pkg::RKS_ROUNDS,
    parameter int unsigned SLICES     = rks_pkg::RKS_SLICES,
    parameter int unsigned LANES      = rks_pkg::RKS_LANES,
    parameter int unsigned BYTE_W     = rks_pkg::RKS_BYTE_W,
    localparam int unsigned WORD_W    = LANES * BYTE_W,
    localparam int unsigned RND_W     = $clog2(NUM_ROUNDS + 1),
    localparam int unsigned SLC_W     = (SLICES > 1) ? $clog2(SLICES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_start,
    input  logic              ld_valid,
    input  logic [RND_W-1:0]  ld_round,
    input  logic [SLC_W-1:0]  ld_slice,
    input  logic [WORD_W-1:0] ld_word,
    input  logic              rd_req,
    input  logic [RND_W-1:0]  rd_round,
    input  logic [SLC_W-1:0]  rd_slice,
    output logic [WORD_W-1:0] key_slice,
    output logic              key_valid,
    output logic              key_err,
    output logic              keys_ready
);
    logic              accept;
    logic              last_word;
    logic              rd_oor;
    logic [WORD_W-1:0] bank_word;
    logic [WORD_W-1:0] seed_word;
    logic [WORD_W-1:0] stored_word;

    assign accept    = ld_valid && !keys_ready && !ld_start;
    assign last_word = accept && (ld_round == RND_W'(NUM_ROUNDS))
                              && (ld_slice == SLC_W'(SLICES - 1));
    assign rd_oor    = rd_round > RND_W'(NUM_ROUNDS);

    rks_bank #(
        .NUM_ROUNDS (NUM_ROUNDS),
        .SLICES     (SLICES),
        .LANES      (LANES),
        .BYTE_W     (BYTE_W)
    ) u_bank (
        .clk      (clk),
        .wr_en    (accept),
        .wr_round (ld_round),
        .wr_slice (ld_slice),
        .wr_word  (ld_word),
        .rd_round (rd_round),
        .rd_slice (rd_slice),
        .rd_word  (bank_word)
    );

    rks_seed_hold #(.SLICES(SLICES), .WORD_W(WORD_W)) u_seed (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (accept && (ld_round == '0)),
        .wslice (ld_slice),
        .wword  (ld_word),
        .rslice (rd_slice),
        .rword  (seed_word)
    );

    assign stored_word = (rd_round == '0) ? seed_word : bank_word;

    // Lock flag: set by the final schedule word, cleared by a new load.
    always_ff @(posedge clk) begin
        if (!rst_n)          keys_ready <= 1'b0;
        else if (ld_start)   keys_ready <= 1'b0;
        else if (last_word)  keys_ready <= 1'b1;
    end

    // Registered read result: stored copy, bypass word, or error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_slice <= '0;
            key_valid <= 1'b0;
            key_err   <= 1'b0;
        end else begin
            key_err   <= rd_req && rd_oor;
            key_valid <= rd_req && !rd_oor && (keys_ready || ld_valid);
            if (rd_req && !rd_oor && keys_ready)
                key_slice <= stored_word;
            else if (rd_req && !rd_oor && ld_valid)
                key_slice <= ld_word;
            else
                key_slice <= '0;
        end
    end
endmodule

// File: rtl/rks_store_chk.sv
// Module: property checker for rks_store, attached with bind below.
// Observes the ports only.
module rks_store_chk #(
    parameter int unsigned NUM_ROUNDS = 10,
    parameter int unsigned RND_W      = 4,
    parameter int unsigned SLC_W      = 2,
    parameter int unsigned WORD_W     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_start,
    input logic              ld_valid,
    input logic [RND_W-1:0]  ld_round,
    input logic [SLC_W-1:0]  ld_slice,
    input logic [WORD_W-1:0] ld_word,
    input logic              rd_req,
    input logic [RND_W-1:0]  rd_round,
    input logic [WORD_W-1:0] key_slice,
    input logic              key_valid,
    input logic              key_err,
    input logic              keys_ready
);
    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!key_valid && !key_err && !keys_ready && key_slice == '0));

    a_r3_ready_needs_last_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(keys_ready) |-> $past(ld_valid && !ld_start
                                    && ld_round == RND_W'(NUM_ROUNDS)
                                    && ld_slice == '1));

    a_r4_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (keys_ready && !ld_start) |=> keys_ready);

    a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ld_start |=> !keys_ready);

    a_r6_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && keys_ready && int'(rd_round) <= int'(NUM_ROUNDS)) |=> key_valid);

    a_r6_quiet_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!key_valid && !key_err));

    a_r8_oor_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && int'(rd_round) > int'(NUM_ROUNDS)) |=>
            (key_err && !key_valid && key_slice == '0));

    a_r9_bypass_word: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !keys_ready && ld_valid && int'(rd_round) <= int'(NUM_ROUNDS))
            |=> (key_valid && key_slice == $past(ld_word)));
endmodule

bind rks_store rks_store_chk #(
    .NUM_ROUNDS (NUM_ROUNDS),
    .RND_W      (RND_W),
    .SLC_W      (SLC_W),
    .WORD_W     (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_start   (ld_start),
    .ld_valid   (ld_valid),
    .ld_round   (ld_round),
    .ld_slice   (ld_slice),
    .ld_word    (ld_word),
    .rd_req     (rd_req),
    .rd_round   (rd_round),
    .key_slice  (key_slice),
    .key_valid  (key_valid),
    .key_err    (key_err),
    .keys_ready (keys_ready)
);

// File: tb/rks_store_tb_top.sv
// Directed bench for rks_store. Inputs change on the falling edge, and
// outputs are sampled on the next falling edge, after the registering edge.
module rks_store_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_start = 1'b0, ld_valid = 1'b0;
    logic [3:0]  ld_round = '0, rd_round = '0;
    logic [1:0]  ld_slice = '0, rd_slice = '0;
    logic [31:0] ld_word = '0;
    logic        rd_req = 1'b0;
    logic [31:0] key_slice;
    logic        key_valid, key_err, keys_ready;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    rks_store dut_i (
        .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_valid(ld_valid),
        .ld_round(ld_round), .ld_slice(ld_slice), .ld_word(ld_word),
        .rd_req(rd_req), .rd_round(rd_round), .rd_slice(rd_slice),
        .key_slice(key_slice), .key_valid(key_valid), .key_err(key_err),
        .keys_ready(keys_ready)
    );

    function automatic logic [31:0] kw(input logic [31:0] seed, input int r, input int s);
        return (32'h9E3779B9 * (r * 4 + s + 1)) ^ seed ^ {r[7:0], s[7:0], 16'h5A00};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_word(input int r, input int s, input logic [31:0] w);
        @(negedge clk);
        ld_valid = 1'b1; ld_round = 4'(r); ld_slice = 2'(s); ld_word = w;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic load_all(input logic [31:0] seed);
        for (int r = 0; r <= 10; r++)
            for (int s = 0; s < 4; s++) begin
                if (r == 10 && s == 3)
                    check(!keys_ready, "R3 early", {31'b0, keys_ready}, 32'd0);
                load_word(r, s, kw(seed, r, s));
            end
        check(keys_ready, "R3 set", {31'b0, keys_ready}, 32'd1);
    endtask

    task automatic read_exp(input int r, input int s, input logic [31:0] exp,
                            input string req);
        @(negedge clk);
        rd_req = 1'b1; rd_round = 4'(r); rd_slice = 2'(s);
        @(negedge clk);
        rd_req = 1'b0;
        check(key_valid && !key_err && key_slice == exp, req, key_slice, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!key_valid && !key_err && !keys_ready && key_slice == 0, "R1",
              {key_slice[31:3], key_valid, key_err, keys_ready}, 32'd0);
    endtask

    task automatic t_full_readback(input logic [31:0] seed);
        for (int r = 1; r <= 10; r++)
            for (int s = 0; s < 4; s++) read_exp(r, s, kw(seed, r, s), "R2 stored");
        for (int s = 0; s < 4; s++) read_exp(0, s, kw(seed, 0, s), "R7 round0");
    endtask

    task automatic t_stream(input logic [31:0] seed);
        @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            rd_req = 1'b1; rd_round = 4'd7; rd_slice = 2'(s);
            @(negedge clk);
            check(key_valid && key_slice == kw(seed, 7, s), "R6 stream", key_slice,
                  kw(seed, 7, s));
        end
        rd_req = 1'b0;
        @(negedge clk);
        check(!key_valid && !key_err, "R6 idle", {30'b0, key_valid, key_err}, 32'd0);
    endtask

    task automatic t_locked_writes(input logic [31:0] seed);
        load_word(5, 2, 32'hDEADBEEF);
        load_word(0, 1, 32'hCAFEF00D);
        read_exp(5, 2, kw(seed, 5, 2), "R4 bank locked");
        read_exp(0, 1, kw(seed, 0, 1), "R4 seed locked");
    endtask

    task automatic t_out_of_range;
        for (int r = 11; r <= 15; r += 4) begin
            @(negedge clk);
            rd_req = 1'b1; rd_round = 4'(r); rd_slice = 2'd1;
            @(negedge clk);
            rd_req = 1'b0;
            check(key_err && !key_valid && key_slice == 0, "R8",
                  {key_slice[31:2], key_valid, key_err}, 32'd1);
        end
    endtask

    task automatic t_restart_bypass(input logic [31:0] old_seed, input logic [31:0] new_seed);
        @(negedge clk);
        ld_start = 1'b1; ld_valid = 1'b1; ld_round = 4'd3; ld_slice = 2'd0;
        ld_word = 32'h0BAD0BAD;
        @(negedge clk);
        ld_start = 1'b0; ld_valid = 1'b0;
        check(!keys_ready, "R5 cleared", {31'b0, keys_ready}, 32'd0);
        // Bypass with a load word present.
        rd_req = 1'b1; rd_round = 4'd4; rd_slice = 2'd2;
        ld_valid = 1'b1; ld_round = 4'd1; ld_slice = 2'd0; ld_word = kw(new_seed, 1, 0);
        @(negedge clk);
        ld_valid = 1'b0; rd_req = 1'b0;
        check(key_valid && key_slice == kw(new_seed, 1, 0), "R9 bypass", key_slice,
              kw(new_seed, 1, 0));
        // Bypass with no load word.
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check(!key_valid && key_slice == 0, "R9 empty", key_slice, 32'd0);
        load_all(new_seed);
        read_exp(3, 0, kw(new_seed, 3, 0), "R5 reload");
        read_exp(10, 3, kw(new_seed, 10, 3), "R5 reload last");
        check(kw(new_seed, 3, 0) != kw(old_seed, 3, 0), "R5 seeds differ",
              kw(new_seed, 3, 0), kw(old_seed, 3, 0));
    endtask

    initial begin
        t_reset();
        load_all(32'h1234_5678);
        t_full_readback(32'h1234_5678);
        t_stream(32'h1234_5678);
        t_locked_writes(32'h1234_5678);
        t_out_of_range();
        t_restart_bypass(32'h1234_5678, 32'hA5C3_0F96);
        t_full_readback(32'hA5C3_0F96);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule